// File: doc/BRIEF.md
# Half-Duplex Host Transaction Sequencer

This block runs one complete command transaction, from the host side, against an authentication device on a single shared half-duplex wire. A token layer below it owns the wire and the bit timing. The sequencer only decides which token goes out next and when. It asks for each token with a request/acknowledge handshake. It streams the command block byte by byte from a buffer it indexes. It counts the parse and execute intervals. Finally, it looks at the wake-sync byte and at the CRC verdict that a separate block checker gives for each response.

One pulse on `start` begins a transaction. The sequencer wakes the device and asks it to transmit. It then checks that the device answered with the sync byte 0x11, and sends the command flag and the command block. Next it waits either the parse interval, a poll, and the execute interval (normal commands), or one combined wait (short commands). Then it asks for the response. If the response fails its CRC, the sequencer asks again, up to a set number of times. Every transaction ends with a sleep token and a one-cycle `done` pulse that carries the error code.

States: IDLE, WAKE, SYNC_TX, SYNC_RX, CMD_FLAG, CMD_BYTES, WAIT_PARSE, POLL_TX, WAIT_EXEC, WAIT_SUM, FETCH_TX, RESP_RX, SLEEP, DONE.

Transitions:
- IDLE→WAKE on start.
- WAKE→SYNC_TX on acknowledge.
- SYNC_TX→SYNC_RX on acknowledge.
- SYNC_RX→CMD_FLAG on a good sync byte, or SYNC_RX→SLEEP on a bad one.
- CMD_FLAG→CMD_BYTES on acknowledge.
- CMD_BYTES→WAIT_PARSE (normal) or CMD_BYTES→WAIT_SUM (short) when the last byte is acknowledged.
- WAIT_PARSE→POLL_TX when the wait expires.
- POLL_TX→WAIT_EXEC on acknowledge.
- WAIT_EXEC→FETCH_TX and WAIT_SUM→FETCH_TX when the wait expires.
- FETCH_TX→RESP_RX on acknowledge.
- RESP_RX→SLEEP on a good CRC or when retries are used up.
- RESP_RX→FETCH_TX on a bad CRC with retries left.
- SLEEP→DONE on acknowledge.
- DONE→IDLE always.

Top module: `hdx_txn_seq`

## Requirements
- R1: After reset, `tok_req`, `done` and `err_code` are 0. A `start` pulse in IDLE makes the next token a wake token, followed by a transmit token. `short_cmd` and `cmd_len` are captured at that start.
- R2: Token kind codes on `tok_kind` are: 1 wake, 2 transmit, 3 command flag, 4 data byte, 5 sleep. While `tok_req` is high and `tok_ack` is low, `tok_req` stays high and `tok_kind` stays unchanged. A token counts as sent in a cycle where both are high.
- R3: After the first transmit token, the sequencer waits for `rx_valid`. A byte of 0x11 leads to a command-flag token. Any other byte leads straight to a sleep token and error code 1.
- R4: After the command flag, exactly `cmd_len` data-byte tokens are sent (`cmd_len` ≥ 1). For each one, `cmd_idx` counts from 0 to `cmd_len`-1 and `tok_data` equals `cmd_byte`.
- R5: For a normal command, the parse wait lasts max(`t_parse`,1) cycles after the last byte is accepted. A poll transmit token follows. After that is accepted, an execute wait of max(`t_exec`,1) cycles comes before the fetch transmit token. With an immediate acknowledge, each gap between token acceptances is the wait plus one cycle.
- R6: For a short command, one wait of max(`t_parse`+`t_exec`,1) cycles follows the last byte, and the fetch transmit token comes after it. No poll token is sent.
- R7: A response with `resp_crc_ok` low causes another fetch transmit token, up to MAX_RETRY extra fetches. A bad CRC after that sends the sleep token and ends with error code 2.
- R8: The sleep token is always the last token. The cycle after it is accepted, `done` is high for exactly one cycle and never together with `tok_req`. `err_code` is 0 on success.
- R9: `rx_valid`, `resp_valid` and `start` outside the states that wait for them start nothing and change no token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (honoured in IDLE only) |
| short_cmd | input | 1 | Use the single combined wait |
| t_parse | input | TIME_W | Parse interval in cycles |
| t_exec | input | TIME_W | Execute interval in cycles |
| cmd_len | input | LEN_W | Command block length in bytes |
| cmd_idx | output | LEN_W | Index of the command byte being sent |
| cmd_byte | input | 8 | Command byte at `cmd_idx` |
| tok_req | output | 1 | Token request to the token layer |
| tok_kind | output | 3 | Kind of the requested token |
| tok_data | output | 8 | Byte for data-byte tokens, else 0 |
| tok_ack | input | 1 | Token layer accepts the request |
| rx_valid | input | 1 | Received sync byte is valid |
| rx_byte | input | 8 | Received sync byte |
| resp_valid | input | 1 | Response block finished |
| resp_crc_ok | input | 1 | Response CRC matched |
| done | output | 1 | Transaction finished (one cycle) |
| err_code | output | 2 | 0 ok, 1 sync failure, 2 CRC retries exhausted |

## Verification
The bench builds the block with TIME_W=8, LEN_W=6 and MAX_RETRY=2. With these values, interval values of 0 and small sums are cheap to reach. The retry limit is used up after only three fetches, so both the recovered-CRC case and the exhausted-CRC case fit in a few hundred cycles. Short blocks of 1 to 5 bytes give the byte-index boundary at both ends. A delayed acknowledge then shows that the sequence holds however long the token layer stalls.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    typedef enum logic [2:0] {
        TK_NONE  = 3'd0,
        TK_WAKE  = 3'd1,
        TK_XMIT  = 3'd2,
        TK_CMD   = 3'd3,
        TK_BYTE  = 3'd4,
        TK_SLEEP = 3'd5
    } tok_kind_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_SYNC = 2'd1,
        ERR_CRC  = 2'd2
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAKE,
        S_SYNC_TX,
        S_SYNC_RX,
        S_CMD_FLAG,
        S_CMD_BYTES,
        S_WAIT_PARSE,
        S_POLL_TX,
        S_WAIT_EXEC,
        S_WAIT_SUM,
        S_FETCH_TX,
        S_RESP_RX,
        S_SLEEP,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/hdx_wait_timer.sv
// Down-counter for the parse / execute waits. A loaded value N gives
// expiry in the N-th cycle after the load (N of 0 behaves as 1).
module hdx_wait_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = (cnt_q <= CW'(1));
endmodule

// File: rtl/hdx_retry_limit.sv
// Counts response re-fetches and flags when no more are allowed.
module hdx_retry_limit #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int RW = $clog2(MAX_RETRY + 2);

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !exhausted) begin
            cnt_q <= cnt_q + RW'(1);
        end
    end

    assign exhausted = (cnt_q == RW'(MAX_RETRY));
endmodule

// File: rtl/hdx_txn_seq.sv
module hdx_txn_seq #(
    parameter int          TIME_W    = 16,
    parameter int          LEN_W     = 6,
    parameter int          MAX_RETRY = 3,
    parameter logic [7:0]  SYNC_BYTE = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              short_cmd,
    input  logic [TIME_W-1:0] t_parse,
    input  logic [TIME_W-1:0] t_exec,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic [LEN_W-1:0]  cmd_idx,
    input  logic [7:0]        cmd_byte,
    output logic              tok_req,
    output logic [2:0]        tok_kind,
    output logic [7:0]        tok_data,
    input  logic              tok_ack,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              resp_valid,
    input  logic              resp_crc_ok,
    output logic              done,
    output logic [1:0]        err_code
);
    import hdx_pkg::*;

    localparam int CW = TIME_W + 1;

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic             short_q;
    err_e             err_q, err_d;
    logic             set_err;

    logic             accepted;
    logic             last_byte;
    logic             tmr_load;
    logic [CW-1:0]    tmr_val;
    logic             tmr_expired;
    logic             rty_clr;
    logic             rty_inc;
    logic             rty_exhausted;

    hdx_wait_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    hdx_retry_limit #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rty_clr),
        .inc       (rty_inc),
        .exhausted (rty_exhausted)
    );

    assign accepted  = tok_req && tok_ack;
    assign last_byte = (idx_q == len_q - LEN_W'(1));

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            short_q <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                idx_q   <= '0;
                len_q   <= cmd_len;
                short_q <= short_cmd;
                err_q   <= ERR_NONE;
            end else begin
                if (state_q == S_CMD_BYTES && accepted) begin
                    idx_q <= idx_q + LEN_W'(1);
                end
                if (set_err) begin
                    err_q <= err_d;
                end
            end
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rty_clr  = 1'b0;
        rty_inc  = 1'b0;
        set_err  = 1'b0;
        err_d    = ERR_NONE;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_WAKE;
                    rty_clr = 1'b1;
                end
            end
            S_WAKE:     if (accepted) state_d = S_SYNC_TX;
            S_SYNC_TX:  if (accepted) state_d = S_SYNC_RX;
            S_SYNC_RX: begin
                if (rx_valid) begin
                    if (rx_byte == SYNC_BYTE) begin
                        state_d = S_CMD_FLAG;
                    end else begin
                        state_d = S_SLEEP;
                        set_err = 1'b1;
                        err_d   = ERR_SYNC;
                    end
                end
            end
            S_CMD_FLAG: if (accepted) state_d = S_CMD_BYTES;
            S_CMD_BYTES: begin
                if (accepted && last_byte) begin
                    tmr_load = 1'b1;
                    if (short_q) begin
                        tmr_val = {1'b0, t_parse} + {1'b0, t_exec};
                        state_d = S_WAIT_SUM;
                    end else begin
                        tmr_val = {1'b0, t_parse};
                        state_d = S_WAIT_PARSE;
                    end
                end
            end
            S_WAIT_PARSE: if (tmr_expired) state_d = S_POLL_TX;
            S_POLL_TX: begin
                if (accepted) begin
                    tmr_load = 1'b1;
                    tmr_val  = {1'b0, t_exec};
                    state_d  = S_WAIT_EXEC;
                end
            end
            S_WAIT_EXEC: if (tmr_expired) state_d = S_FETCH_TX;
            S_WAIT_SUM:  if (tmr_expired) state_d = S_FETCH_TX;
            S_FETCH_TX:  if (accepted) state_d = S_RESP_RX;
            S_RESP_RX: begin
                if (resp_valid) begin
                    if (resp_crc_ok) begin
                        state_d = S_SLEEP;
                    end else if (rty_exhausted) begin
                        state_d = S_SLEEP;
                        set_err = 1'b1;
                        err_d   = ERR_CRC;
                    end else begin
                        state_d = S_FETCH_TX;
                        rty_inc = 1'b1;
                    end
                end
            end
            S_SLEEP: if (accepted) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tok_req  = 1'b0;
        tok_kind = TK_NONE;
        tok_data = 8'h00;
        done     = 1'b0;
        unique case (state_q)
            S_WAKE: begin
                tok_req  = 1'b1;
                tok_kind = TK_WAKE;
            end
            S_SYNC_TX, S_POLL_TX, S_FETCH_TX: begin
                tok_req  = 1'b1;
                tok_kind = TK_XMIT;
            end
            S_CMD_FLAG: begin
                tok_req  = 1'b1;
                tok_kind = TK_CMD;
            end
            S_CMD_BYTES: begin
                tok_req  = 1'b1;
                tok_kind = TK_BYTE;
                tok_data = cmd_byte;
            end
            S_SLEEP: begin
                tok_req  = 1'b1;
                tok_kind = TK_SLEEP;
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign cmd_idx  = idx_q;
    assign err_code = err_q;
endmodule

// File: rtl/hdx_txn_seq_chk.sv
module hdx_txn_seq_chk #(
    parameter logic [7:0] SYNC_BYTE = 8'h11
) (
    input logic                clk,
    input logic                rst_n,
    input hdx_pkg::seq_state_e st,
    input logic                start,
    input logic                tok_req,
    input logic [2:0]          tok_kind,
    input logic                tok_ack,
    input logic                rx_valid,
    input logic [7:0]          rx_byte,
    input logic                resp_valid,
    input logic                resp_crc_ok,
    input logic                done
);
    import hdx_pkg::*;

    // R1
    wake_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && start) |=> (tok_req && tok_kind == TK_WAKE));

    // R2
    tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_req && !tok_ack) |=> (tok_req && $stable(tok_kind)));

    // R3
    sync_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SYNC_RX && rx_valid && rx_byte != SYNC_BYTE)
            |=> (tok_req && tok_kind == TK_SLEEP));

    // R7
    crc_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RESP_RX && resp_valid && !resp_crc_ok)
            |=> (tok_req && (tok_kind == TK_XMIT || tok_kind == TK_SLEEP)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tok_req);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !start) |=> !tok_req);
endmodule

bind hdx_txn_seq hdx_txn_seq_chk #(.SYNC_BYTE(SYNC_BYTE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (state_q),
    .start       (start),
    .tok_req     (tok_req),
    .tok_kind    (tok_kind),
    .tok_ack     (tok_ack),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .resp_valid  (resp_valid),
    .resp_crc_ok (resp_crc_ok),
    .done        (done)
);

// File: tb/tb_hdx_txn_seq.sv
module tb_hdx_txn_seq;
    localparam int TIME_W    = 8;
    localparam int LEN_W     = 6;
    localparam int MAX_RETRY = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              short_cmd = 1'b0;
    logic [TIME_W-1:0] t_parse = '0;
    logic [TIME_W-1:0] t_exec = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [LEN_W-1:0]  cmd_idx;
    logic [7:0]        cmd_byte;
    logic              tok_req;
    logic [2:0]        tok_kind;
    logic [7:0]        tok_data;
    logic              tok_ack = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic              resp_valid = 1'b0;
    logic              resp_crc_ok = 1'b0;
    logic              done;
    logic [1:0]        err_code;

    always #4 clk = ~clk;

    assign cmd_byte = 8'hA0 + 8'(cmd_idx);

    hdx_txn_seq #(.TIME_W(TIME_W), .LEN_W(LEN_W), .MAX_RETRY(MAX_RETRY)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .short_cmd(short_cmd),
        .t_parse(t_parse), .t_exec(t_exec), .cmd_len(cmd_len),
        .cmd_idx(cmd_idx), .cmd_byte(cmd_byte), .tok_req(tok_req),
        .tok_kind(tok_kind), .tok_data(tok_data), .tok_ack(tok_ack),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .resp_valid(resp_valid),
        .resp_crc_ok(resp_crc_ok), .done(done), .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;

    // Responder / model state
    int cyc = 0;
    int ack_dly = 0;
    int ack_wait = 0;
    bit cur_short = 0;
    int xmit_n = 0;
    int rx_at = -1;
    int resp_at = -1;
    logic [7:0] sync_val = 8'h11;
    bit resp_ok_val = 1'b1;
    bit crc_q[$];
    int ev_kind[$];
    int ev_data[$];
    int ev_cyc[$];
    bit done_seen = 0;
    int done_err = 0;
    int done_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-clock reference responder and monitor, away from the active edge
    always @(negedge clk) begin
        cyc++;
        rx_valid   = 1'b0;
        resp_valid = 1'b0;
        if (cyc == rx_at) begin
            rx_valid = 1'b1;
            rx_byte  = sync_val;
        end
        if (cyc == resp_at) begin
            resp_valid  = 1'b1;
            resp_crc_ok = resp_ok_val;
        end
        if (rst_n) begin
            // R8: done never coincides with a token request
            chk(!(done && tok_req), "R8 done/tok_req exclusive", int'(tok_req), 0);
            if (done) begin
                done_seen = 1;
                done_err  = int'(err_code);
                done_cnt++;
            end
        end
        if (tok_req) begin
            if (ack_wait < ack_dly) begin
                ack_wait++;
                tok_ack = 1'b0;
            end else begin
                ack_wait = 0;
                tok_ack  = 1'b1;
                ev_kind.push_back(int'(tok_kind));
                ev_data.push_back(int'(tok_data));
                ev_cyc.push_back(cyc);
                if (tok_kind == 3'd2) begin
                    xmit_n++;
                    if (xmit_n == 1) begin
                        rx_at = cyc + 2;
                    end else if (!(xmit_n == 2 && !cur_short)) begin
                        resp_at     = cyc + 2;
                        resp_ok_val = (crc_q.size() > 0) ? crc_q.pop_front() : 1'b1;
                    end
                end
            end
        end else begin
            tok_ack  = 1'b0;
            ack_wait = 0;
        end
    end

    task automatic run_txn(input bit sh, input int tp, input int te, input int len,
                           input logic [7:0] syncb, input int nfail, input int dly,
                           input bit start_mid);
        int exp_k[$];
        int exp_err;
        int nfetch;
        int w;
        int base;
        bit ok;
        ev_kind.delete(); ev_data.delete(); ev_cyc.delete(); crc_q.delete();
        for (int i = 0; i < nfail; i++) crc_q.push_back(1'b0);
        crc_q.push_back(1'b1);
        xmit_n = 0; done_seen = 0; done_cnt = 0;
        cur_short = sh; sync_val = syncb; ack_dly = dly;
        @(negedge clk);
        short_cmd = sh; t_parse = TIME_W'(tp); t_exec = TIME_W'(te);
        cmd_len = LEN_W'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done_seen && w < 5000) begin
            @(negedge clk);
            w++;
            start = (start_mid && w == 6);
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(done_seen, "R8 done reached (watchdog)", int'(done_seen), 1);
        chk(done_cnt == 1, "R8 done single pulse", done_cnt, 1);
        // Expected token sequence from the requirements
        exp_k.push_back(1); exp_k.push_back(2);
        if (syncb != 8'h11) begin
            exp_err = 1;
        end else begin
            exp_k.push_back(3);
            for (int i = 0; i < len; i++) exp_k.push_back(4);
            if (!sh) exp_k.push_back(2);
            nfetch  = (nfail <= MAX_RETRY) ? nfail + 1 : MAX_RETRY + 1;
            exp_err = (nfail <= MAX_RETRY) ? 0 : 2;
            for (int i = 0; i < nfetch; i++) exp_k.push_back(2);
        end
        exp_k.push_back(5);
        chk(ev_kind.size() == exp_k.size(), "R1/R7/R8 token count", ev_kind.size(), exp_k.size());
        ok = (ev_kind.size() == exp_k.size());
        if (ok) begin
            for (int i = 0; i < exp_k.size(); i++)
                if (ev_kind[i] != exp_k[i]) begin
                    chk(0, "R2 token kind order", ev_kind[i], exp_k[i]);
                    ok = 0;
                end
            if (ok) chk(1, "R2 token kind order", 0, 0);
        end
        chk(done_err == exp_err, "R3/R7/R8 err_code", done_err, exp_err);
        if (ok && syncb == 8'h11) begin
            for (int i = 0; i < len; i++)
                chk(ev_data[3 + i] == ((8'hA0 + i) & 8'hFF), "R4 command byte data",
                    ev_data[3 + i], (8'hA0 + i) & 8'hFF);
            if (dly == 0) begin
                base = 2 + len;
                if (sh) begin
                    w = (tp + te < 1) ? 1 : tp + te;
                    chk(ev_cyc[base + 1] - ev_cyc[base] == w + 1, "R6 combined wait",
                        ev_cyc[base + 1] - ev_cyc[base], w + 1);
                end else begin
                    w = (tp < 1) ? 1 : tp;
                    chk(ev_cyc[base + 1] - ev_cyc[base] == w + 1, "R5 parse wait",
                        ev_cyc[base + 1] - ev_cyc[base], w + 1);
                    w = (te < 1) ? 1 : te;
                    chk(ev_cyc[base + 2] - ev_cyc[base + 1] == w + 1, "R5 execute wait",
                        ev_cyc[base + 2] - ev_cyc[base + 1], w + 1);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tok_req == 1'b0, "R1 reset tok_req", int'(tok_req), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        chk(err_code == 2'd0, "R1 reset err_code", int'(err_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: stray receive events in IDLE start nothing
        ev_kind.delete();
        rx_at = cyc + 1; resp_at = cyc + 2;
        repeat (10) @(negedge clk);
        chk(ev_kind.size() == 0, "R9 idle ignores rx/resp", ev_kind.size(), 0);

        run_txn(0, 5, 7, 4, 8'h11, 0, 0, 0);   // R5 normal
        run_txn(1, 3, 6, 5, 8'h11, 0, 0, 0);   // R6 short
        run_txn(0, 0, 0, 1, 8'h11, 0, 0, 0);   // R5 zero intervals, single byte
        run_txn(1, 0, 0, 2, 8'h11, 0, 0, 0);   // R6 zero sum
        run_txn(0, 2, 3, 3, 8'h5A, 0, 0, 0);   // R3 sync failure
        run_txn(0, 2, 2, 3, 8'h11, 2, 0, 0);   // R7 recovered after retries
        run_txn(1, 1, 1, 2, 8'h11, 3, 0, 0);   // R7 retries exhausted
        run_txn(0, 3, 2, 4, 8'h11, 1, 3, 1);   // R2 slow ack, R9 start while busy

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule